// File: doc/BRIEF.md
# Packed SIMD Multimedia ALU

This block is a lane-parallel arithmetic unit for media kernels. It takes two 64-bit operands and treats each one as a vector of equal-width elements. The element width is chosen per operation: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane is computed on its own, and nothing carries from one lane into the next.

The operation set covers the following:
- wraparound, signed-saturating and unsigned-saturating addition and subtraction;
- a rounding unsigned average;
- a scaled accumulate, which shifts A left by 1 to 3 and then adds B;
- equality and signed greater-than compares, which return full lane masks;
- a lane multiply that keeps the low half of each product.

The multiply exists only at one lane width, which is 16 bits by default. Any combination the block does not support returns an all-zero result and raises an illegal-operation flag.

The datapath has one register stage by default. A parameter selects a purely combinational variant instead. The block is used as one execution unit of a wide-issue core. The issue logic presents operands and control on one clock edge and collects the packed result after the next edge.

Top module: `simd_media_alu`

## Requirements
- R1: `elem_sz` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes and 2 gives 32-bit lanes. Lane i occupies bits [i*w+w-1 : i*w]. No carry or borrow crosses a lane boundary.
- R2: Opcode 0 is the wraparound lane sum A+B and opcode 3 is the wraparound lane difference A-B. Both keep the low w bits.
- R3: Opcode 1 is the signed-saturating add and opcode 4 is the signed-saturating subtract. On overflow the lane clamps to the most positive or most negative two's-complement value.
- R4: Opcode 2 is the unsigned-saturating add and opcode 5 is the unsigned-saturating subtract. The add clamps to all ones, and the subtract clamps to zero when B > A.
- R5: Opcode 6 returns (A+B+1)>>1 per lane on unsigned values. The result is exact even when A+B exceeds w bits.
- R6: Opcode 7 returns ((A << k) + B) mod 2^w per lane, where k = `shl_amt` and k is 1, 2 or 3. With `shl_amt` = 0 the operation is illegal.
- R7: Opcode 8 sets a lane to all ones when A equals B. Opcode 9 sets a lane to all ones when A > B as signed values. Every other lane is all zeros.
- R8: Opcode 10 returns the low 16 bits of each 16-bit lane product A*B. At any other element width it is illegal.
- R9: An operation is illegal when `elem_sz` is 3, when the opcode is 11 to 15, or in the cases named in R6 and R8. An illegal operation gives `res` = 0 and `bad_op` = 1. A legal operation gives `bad_op` = 0.
- R10: `res` and `bad_op` reflect the inputs sampled at the previous rising clock edge. They hold until the next edge. An active-low `rst_n` clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| elem_sz | input | 2 | Lane width select: 0 = 8, 1 = 16, 2 = 32, 3 = reserved |
| op_sel | input | 4 | Operation code (0 to 10 defined) |
| shl_amt | input | 2 | Left shift for the scaled accumulate |
| res | output | 64 | Packed lane result |
| bad_op | output | 1 | Illegal operation flag |

## Verification
Every result in this block comes back after the same delay: exactly one rising edge after its inputs. This holds for all operations, lane widths and illegal combinations.

The bench drives each vector on a falling edge. One nanosecond later it confirms that `res` still holds the previous vector's answer, which shows the output did not change before the clock. At the next falling edge, after exactly one register stage, it compares `res` and `bad_op` with its own lane model.

The bound checker uses single-cycle implications that match this latency. These cover compare outputs being lane masks, self-subtraction giving zero, and flagging of illegal operations.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   localparam int ESZ_W  = 2;
   localparam int OPC_W  = 4;
   localparam int SHAMT_W = 2;

   localparam logic [ESZ_W-1:0] ESZ_8   = 2'd0;
   localparam logic [ESZ_W-1:0] ESZ_16  = 2'd1;
   localparam logic [ESZ_W-1:0] ESZ_32  = 2'd2;
   localparam logic [ESZ_W-1:0] ESZ_RSV = 2'd3;

   localparam logic [OPC_W-1:0] OP_ADD    = 4'd0;
   localparam logic [OPC_W-1:0] OP_ADDSS  = 4'd1;
   localparam logic [OPC_W-1:0] OP_ADDUS  = 4'd2;
   localparam logic [OPC_W-1:0] OP_SUB    = 4'd3;
   localparam logic [OPC_W-1:0] OP_SUBSS  = 4'd4;
   localparam logic [OPC_W-1:0] OP_SUBUS  = 4'd5;
   localparam logic [OPC_W-1:0] OP_AVG    = 4'd6;
   localparam logic [OPC_W-1:0] OP_SHLADD = 4'd7;
   localparam logic [OPC_W-1:0] OP_CMPEQ  = 4'd8;
   localparam logic [OPC_W-1:0] OP_CMPGT  = 4'd9;
   localparam logic [OPC_W-1:0] OP_MULLO  = 4'd10;
   localparam logic [OPC_W-1:0] OP_LAST   = OP_MULLO;

   localparam int NUM_SIZES = 3;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
   import simd_alu_pkg::*;
#(
   parameter int W       = 8,
   parameter bit HAS_MUL = 1'b0
) (
   input  logic [W-1:0]       a,
   input  logic [W-1:0]       b,
   input  logic [OPC_W-1:0]   op,
   input  logic [SHAMT_W-1:0] k,
   output logic [W-1:0]       y
);

   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

   logic [W:0]   sum;
   logic [W:0]   diff;
   logic [W-1:0] avg;
   logic [W-1:0] shl_acc;
   logic [W-1:0] mul_lo;
   logic         add_ovf;
   logic         sub_ovf;
   logic         gt_s;

   always_comb begin
      sum     = {1'b0, a} + {1'b0, b};
      diff    = {1'b0, a} - {1'b0, b};
      add_ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      sub_ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
      // halves added first so the rounded mean never needs a wider adder
      avg     = (a >> 1) + (b >> 1) + {{(W-1){1'b0}}, a[0] | b[0]};
      shl_acc = (a << k) + b;
      gt_s    = $signed(a) > $signed(b);
   end

   generate
      if (HAS_MUL) begin : g_mul
         assign mul_lo = a * b;
      end else begin : g_nomul
         assign mul_lo = '0;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_ADD:    y = sum[W-1:0];
         OP_ADDSS:  y = add_ovf ? (a[W-1] ? SMIN : SMAX) : sum[W-1:0];
         OP_ADDUS:  y = sum[W] ? '1 : sum[W-1:0];
         OP_SUB:    y = diff[W-1:0];
         OP_SUBSS:  y = sub_ovf ? (a[W-1] ? SMIN : SMAX) : diff[W-1:0];
         OP_SUBUS:  y = diff[W] ? '0 : diff[W-1:0];
         OP_AVG:    y = avg;
         OP_SHLADD: y = shl_acc;
         OP_CMPEQ:  y = (a == b) ? '1 : '0;
         OP_CMPGT:  y = gt_s ? '1 : '0;
         OP_MULLO:  y = mul_lo;
         default:   y = '0;
      endcase
   end

endmodule

// File: rtl/simd_width_slice.sv
module simd_width_slice
   import simd_alu_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int LANE_W  = 8,
   parameter bit HAS_MUL = 1'b0
) (
   input  logic [DATA_W-1:0]  a,
   input  logic [DATA_W-1:0]  b,
   input  logic [OPC_W-1:0]   op,
   input  logic [SHAMT_W-1:0] k,
   output logic [DATA_W-1:0]  y
);

   localparam int LANES = DATA_W / LANE_W;

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_split
         $error("simd_width_slice: DATA_W must be a multiple of LANE_W");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         simd_lane #(
            .W       (LANE_W),
            .HAS_MUL (HAS_MUL)
         ) u_lane (
            .a  (a[i*LANE_W +: LANE_W]),
            .b  (b[i*LANE_W +: LANE_W]),
            .op (op),
            .k  (k),
            .y  (y[i*LANE_W +: LANE_W])
         );
      end
   endgenerate

endmodule

// File: rtl/simd_op_decode.sv
module simd_op_decode
   import simd_alu_pkg::*;
#(
   parameter int MUL_W = 16
) (
   input  logic [ESZ_W-1:0]   sz,
   input  logic [OPC_W-1:0]   op,
   input  logic [SHAMT_W-1:0] k,
   output logic               legal
);

   logic [ESZ_W-1:0] mul_sz;

   always_comb begin
      unique case (MUL_W)
         8:       mul_sz = ESZ_8;
         32:      mul_sz = ESZ_32;
         default: mul_sz = ESZ_16;
      endcase
   end

   always_comb begin
      legal = 1'b1;
      if (sz == ESZ_RSV)                    legal = 1'b0;
      if (op > OP_LAST)                     legal = 1'b0;
      if (op == OP_SHLADD && k == '0)       legal = 1'b0;
      if (op == OP_MULLO && sz != mul_sz)   legal = 1'b0;
   end

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
   parameter int DATA_W     = 64,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              legal,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q,
   output logic              bad
);

   logic [DATA_W-1:0] d_gated;

   assign d_gated = legal ? d : '0;

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q   <= '0;
               bad <= 1'b0;
            end else begin
               q   <= d_gated;
               bad <= !legal;
            end
         end
      end else begin : g_comb
         assign q   = d_gated;
         assign bad = !legal;
      end
   endgenerate

endmodule

// File: rtl/simd_media_alu.sv
module simd_media_alu
   import simd_alu_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int MUL_W      = 16,
   parameter bit REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  op_a,
   input  logic [DATA_W-1:0]  op_b,
   input  logic [ESZ_W-1:0]   elem_sz,
   input  logic [OPC_W-1:0]   op_sel,
   input  logic [SHAMT_W-1:0] shl_amt,
   output logic [DATA_W-1:0]  res,
   output logic               bad_op
);

   localparam int MAX_LANE_W = 8 << (NUM_SIZES - 1);

   logic [DATA_W-1:0] slice_y [NUM_SIZES];
   logic [DATA_W-1:0] sel_y;
   logic              legal;

   generate
      if (DATA_W % MAX_LANE_W != 0) begin : g_chk_w
         $error("simd_media_alu: DATA_W must be a multiple of the widest lane");
      end
      if (MUL_W != 8 && MUL_W != 16 && MUL_W != 32) begin : g_chk_mul
         $error("simd_media_alu: MUL_W must be 8, 16 or 32");
      end
      for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
         simd_width_slice #(
            .DATA_W  (DATA_W),
            .LANE_W  (8 << g),
            .HAS_MUL ((8 << g) == MUL_W)
         ) u_slice (
            .a  (op_a),
            .b  (op_b),
            .op (op_sel),
            .k  (shl_amt),
            .y  (slice_y[g])
         );
      end
   endgenerate

   always_comb begin
      unique case (elem_sz)
         ESZ_8:   sel_y = slice_y[0];
         ESZ_16:  sel_y = slice_y[1];
         ESZ_32:  sel_y = slice_y[2];
         default: sel_y = '0;
      endcase
   end

   simd_op_decode #(
      .MUL_W (MUL_W)
   ) u_dec (
      .sz    (elem_sz),
      .op    (op_sel),
      .k     (shl_amt),
      .legal (legal)
   );

   simd_out_stage #(
      .DATA_W     (DATA_W),
      .REGISTERED (REGISTERED)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .legal (legal),
      .d     (sel_y),
      .q     (res),
      .bad   (bad_op)
   );

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
   import simd_alu_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int MUL_W      = 16,
   parameter bit REGISTERED = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [DATA_W-1:0]  op_a,
   input logic [DATA_W-1:0]  op_b,
   input logic [ESZ_W-1:0]   elem_sz,
   input logic [OPC_W-1:0]   op_sel,
   input logic [SHAMT_W-1:0] shl_amt,
   input logic [DATA_W-1:0]  res,
   input logic               bad_op
);

   function automatic logic lanes_are_masks(logic [DATA_W-1:0] v, logic [ESZ_W-1:0] sz);
      int bpl;
      logic ok;
      ok  = 1'b1;
      bpl = 1 << sz;
      for (int i = 0; i < DATA_W / 8; i++) begin
         if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
         if (v[i*8 +: 8] != v[(i / bpl) * bpl * 8 +: 8])   ok = 1'b0;
      end
      return ok;
   endfunction

   logic legal_sz;
   logic is_cmp;
   logic mul_wrong_sz;

   assign legal_sz     = (elem_sz != ESZ_RSV);
   assign is_cmp       = (op_sel == OP_CMPEQ) || (op_sel == OP_CMPGT);
   assign mul_wrong_sz = ((8 << elem_sz) != MUL_W);

   AST_BAD_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op |-> (res == '0)); // R9

   generate
      if (REGISTERED) begin : g_seq
         AST_SUB_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == OP_SUB && op_a == op_b && legal_sz) |=> (res == '0 && !bad_op)); // R2

         AST_CMPEQ_SELF_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == OP_CMPEQ && op_a == op_b && legal_sz) |=> (&res)); // R7

         AST_CMP_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (is_cmp && legal_sz) |=> lanes_are_masks(res, $past(elem_sz))); // R7

         AST_MUL_WIDTH_BAD: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == OP_MULLO && legal_sz && mul_wrong_sz) |=> bad_op); // R8

         AST_SHL_ZERO_BAD: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == OP_SHLADD && shl_amt == '0) |=> bad_op); // R6

         AST_RSV_SIZE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
            (!legal_sz) |=> (bad_op && res == '0)); // R9
      end
   endgenerate

endmodule

bind simd_media_alu simd_alu_chk #(
   .DATA_W     (DATA_W),
   .MUL_W      (MUL_W),
   .REGISTERED (REGISTERED)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_a    (op_a),
   .op_b    (op_b),
   .elem_sz (elem_sz),
   .op_sel  (op_sel),
   .shl_amt (shl_amt),
   .res     (res),
   .bad_op  (bad_op)
);

// File: tb/tb_simd_media_alu.sv
module tb_simd_media_alu;

   logic        clk;
   logic        rst_n;
   logic [63:0] op_a;
   logic [63:0] op_b;
   logic [1:0]  elem_sz;
   logic [3:0]  op_sel;
   logic [1:0]  shl_amt;
   logic [63:0] res;
   logic        bad_op;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   simd_media_alu dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_a    (op_a),
      .op_b    (op_b),
      .elem_sz (elem_sz),
      .op_sel  (op_sel),
      .shl_amt (shl_amt),
      .res     (res),
      .bad_op  (bad_op)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   // returns {bad, result}
   function automatic logic [64:0] model(logic [63:0] a, logic [63:0] b,
                                         logic [1:0] sz, logic [3:0] op, logic [1:0] k);
      logic [63:0] r;
      int w;
      longint msk, ea, eb, sa, sb, v, smax, smin;
      if (sz == 2'd3 || op > 4'd10 || (op == 4'd7 && k == 2'd0) ||
          (op == 4'd10 && sz != 2'd1))
         return {1'b1, 64'd0};
      w    = 8 << sz;
      msk  = (longint'(1) << w) - 1;
      smax = (longint'(1) << (w - 1)) - 1;
      smin = -(longint'(1) << (w - 1));
      r    = '0;
      for (int l = 0; l < 64 / w; l++) begin
         ea = longint'((a >> (l * w))) & msk;
         eb = longint'((b >> (l * w))) & msk;
         sa = (ea > smax) ? ea - (msk + 1) : ea;
         sb = (eb > smax) ? eb - (msk + 1) : eb;
         case (op)
            4'd0: v = ea + eb;
            4'd1: begin v = sa + sb; if (v > smax) v = smax; if (v < smin) v = smin; end
            4'd2: begin v = ea + eb; if (v > msk) v = msk; end
            4'd3: v = ea - eb;
            4'd4: begin v = sa - sb; if (v > smax) v = smax; if (v < smin) v = smin; end
            4'd5: begin v = ea - eb; if (v < 0) v = 0; end
            4'd6: v = (ea + eb + 1) >> 1;
            4'd7: v = (ea << k) + eb;
            4'd8: v = (ea == eb) ? msk : 0;
            4'd9: v = (sa > sb) ? msk : 0;
            default: v = ea * eb;
         endcase
         r = r | (64'(v & msk) << (l * w));
      end
      return {1'b0, r};
   endfunction

   function automatic string tag_of(logic [1:0] sz, logic [3:0] op);
      if (sz == 2'd3 || op > 4'd10) return "R9";
      case (op)
         4'd0, 4'd3: return "R2";
         4'd1, 4'd4: return "R3";
         4'd2, 4'd5: return "R4";
         4'd6:       return "R5";
         4'd7:       return "R6";
         4'd8, 4'd9: return "R7";
         default:    return "R8";
      endcase
   endfunction

   task automatic check(string tag, logic [63:0] got_r, logic got_b,
                        logic [63:0] exp_r, logic exp_b);
      n_checks++;
      if (got_r !== exp_r || got_b !== exp_b) begin
         n_fail++;
         $display("FAIL %s: res=%h bad=%b expected res=%h bad=%b", tag, got_r, got_b, exp_r, exp_b);
      end
   endtask

   task automatic apply(logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                        logic [3:0] op, logic [1:0] k, string tag);
      logic [64:0] exp;
      logic [63:0] prev_r;
      logic        prev_b;
      @(negedge clk);
      prev_r  = res;
      prev_b  = bad_op;
      op_a    = a;
      op_b    = b;
      elem_sz = sz;
      op_sel  = op;
      shl_amt = k;
      exp     = model(a, b, sz, op, k);
      #1;
      check("R10", res, bad_op, prev_r, prev_b);
      @(negedge clk);
      check(tag, res, bad_op, exp[63:0], exp[64]);
   endtask

   initial begin
      rst_n   = 1'b0;
      op_a    = 64'h0123_4567_89AB_CDEF;
      op_b    = 64'hFFFF_0000_FFFF_0000;
      elem_sz = 2'd0;
      op_sel  = 4'd0;
      shl_amt = 2'd1;
      repeat (3) @(negedge clk);
      check("R10", res, bad_op, 64'd0, 1'b0);
      rst_n = 1'b1;

      // R1: lane boundaries stop carries at each width
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 4'd0, 2'd1, "R1");
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'd1, 4'd0, 2'd1, "R1");
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 4'd0, 2'd1, "R1");
      apply(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'd2, 4'd3, 2'd1, "R1");
      // R3: signed saturation both directions
      apply(64'h7F80_7F80_0000_0000, 64'h0101_FFFF_0000_0000, 2'd0, 4'd1, 2'd1, "R3");
      apply(64'h8000_7FFF_8000_7FFF, 64'h0001_FFFF_0001_FFFF, 2'd1, 4'd4, 2'd1, "R3");
      // R4: unsigned saturation
      apply(64'hFFF0_0010_FFF0_0010, 64'h0020_0020_0020_0020, 2'd1, 4'd2, 2'd1, "R4");
      apply(64'h0010_0030_0010_0030, 64'h0020_0020_0020_0020, 2'd1, 4'd5, 2'd1, "R4");
      // R5: average at the top of the range
      apply(64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_0000_0000, 2'd2, 4'd6, 2'd1, "R5");
      apply(64'hFFFE_0001_FF01_0203, 64'hFFFF_0000_FF02_0304, 2'd0, 4'd6, 2'd1, "R5");
      // R6: all shift amounts and the illegal zero shift
      for (int k = 0; k < 4; k++)
         apply(64'h8123_4567_89AB_CDEF, 64'h1111_2222_3333_4444, 2'd0, 4'd7, 2'(k), "R6");
      // R7: compares
      apply(64'h0080_7F00_1234_5678, 64'h0080_8000_1234_5679, 2'd0, 4'd8, 2'd1, "R7");
      apply(64'h0080_7F00_1234_5678, 64'h0080_8000_1234_5679, 2'd0, 4'd9, 2'd1, "R7");
      apply(64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 2'd2, 4'd9, 2'd1, "R7");
      // R8: multiply at 16 bits, and at other widths
      apply(64'hFFFF_1234_0100_00FF, 64'hFFFF_0010_0100_00FF, 2'd1, 4'd10, 2'd1, "R8");
      apply(64'h0000_0002_0000_0003, 64'h0000_0004_0000_0005, 2'd0, 4'd10, 2'd1, "R8");
      apply(64'h0000_0002_0000_0003, 64'h0000_0004_0000_0005, 2'd2, 4'd10, 2'd1, "R8");
      // R9: reserved size and undefined opcodes
      apply(64'h1, 64'h2, 2'd3, 4'd0, 2'd1, "R9");
      apply(64'h1, 64'h2, 2'd1, 4'd15, 2'd1, "R9");
      apply(64'h1, 64'h2, 2'd0, 4'd11, 2'd1, "R9");

      void'($urandom(32'h00C0_FFEE));
      for (int n = 0; n < 3000; n++) begin
         logic [63:0] a, b;
         logic [1:0]  sz;
         logic [3:0]  op;
         logic [1:0]  k;
         int          sel;
         a   = {$urandom, $urandom};
         b   = {$urandom, $urandom};
         sel = $urandom_range(0, 5);
         if (sel == 0) b = a;
         if (sel == 1) a = {8{8'h80}} ^ {56'd0, a[7:0]};
         if (sel == 2) b = {8{8'h7F}};
         sz  = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
         op  = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(11, 15)) : 4'($urandom_range(0, 10));
         k   = 2'($urandom_range(0, 3));
         apply(a, b, sz, op, k, tag_of(sz, op));
      end

      // reset clears a non-zero output
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 4'd0, 2'd1, "R2");
      rst_n = 1'b0;
      #1;
      check("R10", res, bad_op, 64'd0, 1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         repeat (200000) @(posedge clk);
      join_any
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule